// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a clocked host and an external 256K-word by 16-bit static RAM that has no clock of its own. The host hands it one request at a time over a valid/ready handshake: a word address, a read/write flag, write data and a per-byte enable mask. The controller then plays out the access on the memory pins. It drives an active-low and an active-high chip enable, one active-low strobe per byte lane, an active-low write strobe and an active-low output enable. The data bus is split into an output word, a drive enable and an input word, so a pad ring can build the tri-state buffer.

Every analog timing figure of the memory is given in nanoseconds as an elaboration parameter. Each one becomes a whole number of clock cycles by rounding up against the clock period parameter. A small state machine with one cycle counter then holds each phase for that many cycles. Writes raise the enables first and pull the write strobe low only afterwards. Because of this ordering the memory never turns its outputs on during a write. The controller also waits until the memory's outputs have had time to release before it drives the bus. A power-down input parks the memory deselected. When that input is released, the controller keeps the memory deselected for a long recovery interval before it accepts any new work.

Top module: `sram_ctrl`

## Requirements
- R1: Whenever no access is in progress (idle, power-down, recovery, reset), mem_ce_n is 1, mem_ce is 0, both mem_lane_n bits are 1, and mem_wr_n and mem_oe_n are 1. During an access mem_ce_n is 0 and mem_ce is 1.
- R2: req_be bit 0 enables data bits 7:0 and drives mem_lane_n bit 0 low; req_be bit 1 enables bits 15:8 and drives mem_lane_n bit 1 low. A write changes only the enabled bytes of the stored word. A mask of 00 leaves both lane strobes high, so such a write stores nothing and such a read returns 0.
- R3: In a write, mem_wr_n goes low only after the enables and lane strobes have been active for at least one cycle. It then stays low for exactly ceil(55 ns / clock period) cycles, and mem_oe_n stays 1 for as long as mem_wr_n is 0.
- R4: A write keeps the memory selected for at least ceil(70 ns / clock period) cycles. mem_addr does not change while the memory stays selected.
- R5: mem_dq_oe is 1 only during a write. It is 1 only after mem_oe_n has been 1 for at least ceil(25 ns / clock period) whole cycles, and it is 1 for the whole time mem_wr_n is low.
- R6: A read holds mem_oe_n at 0 and mem_wr_n at 1 for exactly ceil(70 ns / clock period) selected cycles. The bus is captured on the last of those cycles. In the next cycle rd_valid is 1 for one cycle, with rd_data holding the enabled bytes and zeros in the disabled bytes.
- R7: req_ready is 1 only when the controller is idle and pd_req is 0. A request is taken on a clock edge where both req_valid and req_ready are 1.
- R8: A pd_req that is high while the controller is idle puts it in power-down, and an access already running finishes first. After pd_req falls, the memory stays deselected and req_ready stays 0 for ceil(T_PDREC_NS / clock period) cycles before the controller goes idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request (level) |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enable mask, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, disabled bytes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_lane_n | output | 2 | Active-low byte lane strobes |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The bench issues a write immediately after a read. There the drive enable must wait for the output-release window, and a controller that skipped this wait would fight the memory's outputs on the bus. Masks of 00, 01 and 10 are mixed with full-word traffic at the top address. A lane decode error then leaves stray bytes in the stored word or in the returned word. A power-down request made during a write must let the write strobe finish its full width. The recovery count after release is measured exactly, so a counter that is one cycle off, or that grants access early, shows up at once.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RECOVER,
    ST_PWRDN
  } sram_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 5,
  parameter int T_RC_NS    = 70,
  parameter int T_AA_NS    = 70,
  parameter int T_WC_NS    = 70,
  parameter int T_WP_NS    = 55,
  parameter int T_DS_NS    = 30,
  parameter int T_OHZ_NS   = 25,
  parameter int T_PDREC_NS = 5000000,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output sram_state_e       st,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BE_W-1:0]   be_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              bus_quiet,
  output logic              wr_pulse,
  output logic              rd_last
);

  localparam int RD_CYC  = imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
  localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int SU_CYC  = imax(1, WC_CYC - WP_CYC);
  localparam int WR_CYC  = SU_CYC + WP_CYC;
  localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int REC_CYC = ns_to_cyc(T_PDREC_NS, CLK_NS);
  localparam int MAX_CYC = imax(REC_CYC, imax(RD_CYC, WR_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int Q_W     = $clog2(OHZ_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [Q_W-1:0]   qcnt;
  logic             take;
  logic             cnt_done_rd;
  logic             cnt_done_wr;
  logic             cnt_done_rec;

  assign req_ready    = (st == ST_IDLE) && !pd_req;
  assign take         = req_ready && req_valid;
  assign bus_quiet    = (qcnt >= Q_W'(OHZ_CYC));
  assign cnt_done_rd  = (cnt == CNT_W'(RD_CYC - 1));
  assign cnt_done_wr  = (cnt == CNT_W'(WR_CYC - 1));
  assign cnt_done_rec = (cnt == CNT_W'(REC_CYC - 1));
  assign wr_pulse     = (st == ST_WRITE) && bus_quiet && (cnt >= CNT_W'(SU_CYC));
  assign rd_last      = (st == ST_READ) && cnt_done_rd;

  // cycles that have passed since the output enable was last low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               qcnt <= Q_W'(OHZ_CYC);
    else if (st == ST_READ)   qcnt <= '0;
    else if (!bus_quiet)      qcnt <= qcnt + Q_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (pd_req) begin
            st <= ST_PWRDN;
          end else if (take) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            st      <= req_we ? ST_WRITE : ST_READ;
          end
        end
        ST_READ: begin
          if (cnt_done_rd) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WRITE: begin
          if (bus_quiet) begin
            if (cnt_done_wr) begin
              st  <= ST_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_PWRDN: begin
          cnt <= '0;
          if (!pd_req) st <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (cnt_done_rec) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (st == ST_READ || st == ST_WRITE));

  // R8
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PWRDN && !pd_req) |=> (st == ST_RECOVER));

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_state_e       st,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [BE_W-1:0]   be_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              bus_quiet,
  input  logic              wr_pulse,
  input  logic              rd_last,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic [BE_W-1:0]   mem_lane_n,
  output logic              mem_wr_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic sel;
  logic [DATA_W-1:0] cap_data;

  assign sel        = (st == ST_READ) || (st == ST_WRITE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !sel;
  assign mem_ce     = sel;
  assign mem_lane_n = sel ? ~be_q : '1;
  assign mem_wr_n   = !wr_pulse;
  assign mem_oe_n   = (st != ST_READ);
  assign mem_dq_o   = wdata_q;
  assign mem_dq_oe  = (st == ST_WRITE) && bus_quiet;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign cap_data[g*8 +: 8] = be_q[g] ? mem_dq_i[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_last;
      if (rd_last) rd_data <= cap_data;
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lane_n == '1 && mem_wr_n && mem_oe_n && !mem_ce));

  // R3
  wr_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_oe_n && !mem_ce_n && mem_ce));

  // R3
  wr_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> ($past(!mem_ce_n) && $stable(mem_lane_n)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R5
  drv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  // R6
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 5,
  parameter int T_RC_NS    = 70,
  parameter int T_AA_NS    = 70,
  parameter int T_WC_NS    = 70,
  parameter int T_WP_NS    = 55,
  parameter int T_DS_NS    = 30,
  parameter int T_OHZ_NS   = 25,
  parameter int T_PDREC_NS = 5000000,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic [BE_W-1:0]   mem_lane_n,
  output logic              mem_wr_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  sram_state_e       st;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              bus_quiet;
  logic              wr_pulse;
  logic              rd_last;

  sram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
    .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_WC_NS(T_WC_NS),
    .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS), .T_OHZ_NS(T_OHZ_NS),
    .T_PDREC_NS(T_PDREC_NS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .st(st), .addr_q(addr_q), .be_q(be_q), .wdata_q(wdata_q),
    .bus_quiet(bus_quiet), .wr_pulse(wr_pulse), .rd_last(rd_last)
  );

  sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st), .addr_q(addr_q), .be_q(be_q),
    .wdata_q(wdata_q), .bus_quiet(bus_quiet), .wr_pulse(wr_pulse),
    .rd_last(rd_last), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_lane_n(mem_lane_n), .mem_wr_n(mem_wr_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

endmodule

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

  localparam int CLK_NS = 5;
  localparam int REC_NS = 2000;

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int WP_C  = 11;   // ceil(55/5)
  localparam int WC_C  = 14;   // ceil(70/5)
  localparam int RD_C  = 14;
  localparam int OHZ_C = 5;    // ceil(25/5)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_ce, mem_wr_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_o;
  logic [15:0] mem_dq_i = 16'h5A5A;
  logic [17:0] mem_addr;
  logic [1:0]  mem_lane_n;

  always #2.5 clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS), .T_PDREC_NS(REC_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_ce(mem_ce), .mem_lane_n(mem_lane_n), .mem_wr_n(mem_wr_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int nvec = 0, nerr = 0;
  logic [15:0] refm [int];
  logic [15:0] mdl [int];
  logic [15:0] exp_q [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] rd_ref(input logic [17:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 16'h0000;
  endfunction

  // pin monitor and memory model, sampled mid-cycle
  logic prev_sel = 1'b0, prev_wlow = 1'b0, prev_rdv = 1'b0, run_rd = 1'b0;
  logic [1:0]  prev_lane = 2'b11;
  logic [17:0] prev_addr = '0;
  int werun = 0, selrun = 0, hirun = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      logic sel;
      logic [15:0] w;
      sel = !mem_ce_n && mem_ce;
      // R1 enables always of opposite polarity; idle pins parked
      if (mem_ce_n == mem_ce) chk("R1 enable pair", {mem_ce_n, mem_ce}, 2'b10);
      if (!sel) chk("R1 idle pins", {mem_lane_n, mem_wr_n, mem_oe_n}, 4'b1111);
      // R3 strobe ordering
      if (!mem_wr_n) begin
        chk("R3 oe high under write", mem_oe_n, 1'b1);
        chk("R3 selected before strobe", {sel, prev_sel}, 2'b11);
        chk("R3 lanes steady", mem_lane_n, prev_lane);
        chk("R5 driving under strobe", mem_dq_oe, 1'b1);
        werun++;
      end else if (prev_wlow) begin
        chk("R3 strobe width", werun, WP_C);
        werun = 0;
      end
      // R4 address steady
      if (sel && prev_sel) chk("R4 address steady", mem_addr, prev_addr);
      // R5 drive only after release window
      if (mem_dq_oe) begin
        chk("R5 drive with oe high", {mem_oe_n, sel}, 2'b11);
        chk("R5 release window", (hirun >= OHZ_C), 1'b1);
      end
      // R6 read pin state
      if (!mem_oe_n) chk("R6 read keeps wr high", mem_wr_n, 1'b1);
      // select run lengths
      if (sel) begin
        selrun++;
        if (!mem_oe_n) run_rd = 1'b1;
      end else if (prev_sel) begin
        if (run_rd) chk("R6 read length", selrun, RD_C);
        else chk("R4 write length", (selrun >= WC_C), 1'b1);
        selrun = 0;
        run_rd = 1'b0;
      end
      // R7 ready gating
      if (sel || pd_req) chk("R7 ready low", req_ready, 1'b0);
      // R6 read result
      if (rd_valid) begin
        chk("R6 single pulse", prev_rdv, 1'b0);
        if (exp_q.size() == 0) chk("R6 unexpected rd_valid", 1'b1, 1'b0);
        else chk("R6 read data", rd_data, exp_q.pop_front());
      end
      // memory model: store enabled bytes while the write strobe is low
      if (sel && !mem_wr_n) begin
        w = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 16'h0000;
        if (!mem_lane_n[0]) w[7:0]  = mem_dq_o[7:0];
        if (!mem_lane_n[1]) w[15:8] = mem_dq_o[15:8];
        mdl[int'(mem_addr)] = w;
      end
      if (sel && !mem_oe_n && mem_wr_n) begin
        w = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 16'h0000;
        mem_dq_i <= {mem_lane_n[1] ? 8'hA5 : w[15:8], mem_lane_n[0] ? 8'h5A : w[7:0]};
      end else begin
        mem_dq_i <= 16'h5A5A;
      end
      hirun     = mem_oe_n ? hirun + 1 : 0;
      prev_sel  = sel;
      prev_wlow = !mem_wr_n;
      prev_lane = mem_lane_n;
      prev_addr = mem_addr;
      prev_rdv  = rd_valid;
    end
  end

  task automatic do_req(input logic we, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    if (we) refm[int'(a)] = (rd_ref(a) & ~lane_mask(be)) | (d & lane_mask(be));
    else exp_q.push_back(rd_ref(a) & lane_mask(be));
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || !req_ready) && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  logic finished = 1'b0;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {mem_ce_n, mem_ce, mem_lane_n, mem_wr_n, mem_oe_n, mem_dq_oe},
        7'b1011110);
    chk("R7 ready after reset", req_ready, 1'b1);
    chk("R6 no rd_valid at reset", rd_valid, 1'b0);

    // R2 lane writes at the top address, then masked reads
    do_req(1'b1, 18'h3FFFF, 16'h1234, 2'b11);
    do_req(1'b1, 18'h3FFFF, 16'hABCD, 2'b01);
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
    do_req(1'b1, 18'h3FFFF, 16'hEE00, 2'b10);
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b01);
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b10);
    // R2 mask 00: nothing stored, read returns 0
    do_req(1'b1, 18'h00005, 16'hFFFF, 2'b00);
    do_req(1'b0, 18'h00005, 16'h0000, 2'b11);
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b00);
    // R5 write straight after a read must wait for the release window
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
    do_req(1'b1, 18'h00001, 16'h55AA, 2'b11);
    do_req(1'b0, 18'h00001, 16'h0000, 2'b11);
    drain();
    chk("R6 all reads returned", exp_q.size(), 0);

    // R8 power-down raised during a write: write completes, then recovery
    do_req(1'b1, 18'h00002, 16'hC3C3, 2'b11);
    pd_req = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8 parked deselected", {mem_ce_n, mem_ce, req_ready}, 3'b100);
    @(posedge clk); #1 pd_req = 1'b0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!req_ready && n < 5000);
      chk("R8 recovery length", n, cyc(REC_NS) + 2);
    end
    do_req(1'b0, 18'h00002, 16'h0000, 2'b11);
    drain();

    // random traffic
    for (int i = 0; i < 300; i++) begin
      logic we;
      logic [17:0] a;
      we = $urandom_range(0, 1) == 1;
      a  = ($urandom_range(0, 7) == 0) ? 18'h3FFFF : 18'($urandom_range(0, 15));
      do_req(we, a, 16'($urandom), 2'($urandom_range(0, 3)));
      repeat ($urandom_range(0, 2)) @(posedge clk);
    end
    drain();
    chk("R6 all random reads returned", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule